// File: doc/BRIEF.md
# Serial Bit-Stream Validity Monitor

This block observes a recovered serial stream that arrives one bit per clock, qualified by a bit-valid strobe, and produces a verdict on whether the stream looks like healthy 8b/10b-coded framed traffic. It applies two tests. The first is a run-length test: a line code of this kind never holds the same level for long. The second is a comma test: the seven-bit leading pattern of the positive-disparity K28.5 comma must appear regularly.

Time is divided into windows of a fixed number of accepted bits, 2^WIN_LOG2 with a default of 2^15. A free-running counter of accepted bits marks each window. Errors found during a window are held until the window closes. The registered `data_valid` output and the two per-window error flags change only at that boundary. A downstream loop switch can therefore use `data_valid` to route around a source that sends garbage.

Top module: `serial_validity_monitor`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `data_valid`, `win_rlv_err` and `win_ncd_err` are all 0.
- R2: A window's run-length flag is set when, during that window, an accepted bit makes a run of six or more identical accepted bits (all 0s or all 1s). A run of exactly five does not set it.
- R3: A window's missing-comma flag is set when no accepted seven-bit sequence 0011111 completes within it. The sequence is matched in arrival order: the earliest of the seven bits must be 0 and the latest must be 1.
- R4: Reset empties the comma history. No comma can match until seven bits have been accepted after reset, whatever bits arrived before the reset.
- R5: A window ends on the cycle that accepts its 2^WIN_LOG2-th bit. `data_valid` and both flags are updated on that clock edge only and otherwise hold their value.
- R6: When a window closes with either flag set, `data_valid` is 0 from the next window onward. It stays 0 until a window closes with no error of either kind.
- R7: When a window closes with neither error, `data_valid` is 1 from the next window onward.
- R8: Cycles with `bit_valid` low are ignored. They do not advance the window counter, do not break or extend a run, and do not enter the comma history.
- R9: Run and comma state carries across window boundaries. A run or comma that straddles a boundary counts in the window in which its last bit arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | High when `bit_in` carries an accepted bit |
| data_valid | output | 1 | Registered stream-valid verdict |
| win_rlv_err | output | 1 | Run-length error seen in the last completed window |
| win_ncd_err | output | 1 | No comma seen in the last completed window |

## Verification
Both error detectors act in the same cycle as the bit that completes a run or a comma. Every output is registered behind the window-closing edge, so each result is due exactly one clock after the window's last bit is accepted. The bench drives each bit at the falling edge and checks all three outputs at the next falling edge. It holds its expected values constant between boundaries, so a verdict that changes early, late or mid-window is caught on the very bit where it differs. Windows of 32 bits keep the run-length sweep, gap insertion and boundary-straddling cases short.

// File: rtl/svm_pkg.sv
package svm_pkg;

    localparam int              RUN_LIMIT = 5;
    localparam int              COMMA_LEN = 7;
    localparam logic [COMMA_LEN-1:0] COMMA_PAT = 7'b0011111;

    typedef struct packed {
        logic rlv;
        logic ncd;
    } win_err_t;

    function automatic logic is_comma(input logic [COMMA_LEN-1:0] hist);
        return hist == COMMA_PAT;
    endfunction

endpackage

// File: rtl/svm_run_check.sv
module svm_run_check #(
    parameter int RUN_LIMIT = svm_pkg::RUN_LIMIT
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic bit_in,
    output logic rlv_hit
);
    localparam int             CW  = $clog2(RUN_LIMIT + 2);
    localparam logic [CW-1:0]  SAT = CW'(RUN_LIMIT + 1);
    localparam logic [CW-1:0]  LIM = CW'(RUN_LIMIT);

    logic [CW-1:0] run_q, run_next;
    logic          last_q, have_q, same;

    always_comb begin
        same     = have_q && (bit_in == last_q);
        run_next = same ? ((run_q == SAT) ? SAT : run_q + 1'b1) : CW'(1);
        rlv_hit  = bit_valid && (run_next > LIM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            last_q <= 1'b0;
            have_q <= 1'b0;
        end else if (bit_valid) begin
            run_q  <= run_next;
            last_q <= bit_in;
            have_q <= 1'b1;
        end
    end

    // R2
    rlv_same_chk: assert property (@(posedge clk) disable iff (rst)
        rlv_hit |-> (have_q && bit_in == last_q));

    // R8
    rlv_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |-> !rlv_hit);

endmodule

// File: rtl/svm_comma_check.sv
module svm_comma_check (
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic bit_in,
    output logic comma_hit
);
    import svm_pkg::*;

    localparam int            FW   = $clog2(COMMA_LEN);
    localparam logic [FW-1:0] FULL = FW'(COMMA_LEN - 1);

    logic [COMMA_LEN-1:0] hist_q, hist_next;
    logic [FW-1:0]        fill_q;

    always_comb begin
        hist_next = {hist_q[COMMA_LEN-2:0], bit_in};
        comma_hit = bit_valid && (fill_q == FULL) && is_comma(hist_next);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            fill_q <= '0;
        end else if (bit_valid) begin
            hist_q <= hist_next;
            if (fill_q != FULL) fill_q <= fill_q + 1'b1;
        end
    end

    // R3
    comma_tail_chk: assert property (@(posedge clk) disable iff (rst)
        comma_hit |-> (bit_valid && bit_in));

endmodule

// File: rtl/svm_window.sv
module svm_window #(
    parameter int WIN_LOG2 = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_valid,
    input  logic              rlv_hit,
    input  logic              comma_hit,
    output logic              data_valid,
    output svm_pkg::win_err_t win_err
);
    logic [WIN_LOG2-1:0] cnt_q;
    logic                rlv_seen_q, comma_seen_q, last_bit;
    svm_pkg::win_err_t   closing;

    always_comb begin
        last_bit    = bit_valid && (&cnt_q);
        closing.rlv = rlv_seen_q | rlv_hit;
        closing.ncd = !(comma_seen_q | comma_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q        <= '0;
            rlv_seen_q   <= 1'b0;
            comma_seen_q <= 1'b0;
            data_valid   <= 1'b0;
            win_err      <= '0;
        end else begin
            if (bit_valid) cnt_q <= cnt_q + 1'b1;
            if (last_bit) begin
                rlv_seen_q   <= 1'b0;
                comma_seen_q <= 1'b0;
                win_err      <= closing;
                data_valid   <= !(closing.rlv || closing.ncd);
            end else begin
                if (rlv_hit)   rlv_seen_q   <= 1'b1;
                if (comma_hit) comma_seen_q <= 1'b1;
            end
        end
    end

    // R5
    verdict_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !last_bit |=> ($stable(data_valid) && $stable(win_err)));

    // R6
    err_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (last_bit && (rlv_seen_q || rlv_hit)) |=> !data_valid);

    // R7
    clean_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (last_bit && !rlv_seen_q && !rlv_hit && (comma_seen_q || comma_hit)) |=> data_valid);

endmodule

// File: rtl/serial_validity_monitor.sv
module serial_validity_monitor #(
    parameter int WIN_LOG2  = 15,
    parameter int RUN_LIMIT = svm_pkg::RUN_LIMIT
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic bit_valid,
    output logic data_valid,
    output logic win_rlv_err,
    output logic win_ncd_err
);
    logic              rlv_hit, comma_hit;
    svm_pkg::win_err_t win_err;

    svm_run_check #(.RUN_LIMIT(RUN_LIMIT)) i_run (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in), .rlv_hit(rlv_hit)
    );

    svm_comma_check i_comma (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in), .comma_hit(comma_hit)
    );

    svm_window #(.WIN_LOG2(WIN_LOG2)) i_win (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .rlv_hit(rlv_hit),
        .comma_hit(comma_hit), .data_valid(data_valid), .win_err(win_err)
    );

    assign win_rlv_err = win_err.rlv;
    assign win_ncd_err = win_err.ncd;

    generate
        if (RUN_LIMIT >= 5) begin : g_excl
            // R2 (a completed comma ends a run of exactly five ones)
            comma_not_rlv_chk: assert property (@(posedge clk) disable iff (rst)
                comma_hit |-> !rlv_hit);
        end
    endgenerate

endmodule

// File: tb/test_serial_validity_monitor.sv
module test_serial_validity_monitor;
    localparam int WIN_LOG2 = 5;
    localparam int WIN      = 1 << WIN_LOG2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic bit_valid = 1'b0;
    logic data_valid, win_rlv_err, win_ncd_err;

    always #2.5 clk = ~clk;

    serial_validity_monitor #(.WIN_LOG2(WIN_LOG2)) i_serial_validity_monitor (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_valid(bit_valid),
        .data_valid(data_valid), .win_rlv_err(win_rlv_err), .win_ncd_err(win_ncd_err)
    );

    int    errors = 0;
    int    checks = 0;
    string cur_tag = "R1";

    // bench model state
    logic       exp_dv, exp_rlv, exp_ncd;
    logic       have_prev, m_last, s_rlv, s_comma;
    int         m_run, m_fill, m_cnt;
    logic [6:0] m_hist;

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        exp_dv = 0; exp_rlv = 0; exp_ncd = 0;
        have_prev = 0; m_last = 0; s_rlv = 0; s_comma = 0;
        m_run = 0; m_fill = 0; m_cnt = 0; m_hist = '0;
    endtask

    task automatic model_bit(input logic b);
        if (have_prev && b == m_last) m_run++; else m_run = 1;
        have_prev = 1; m_last = b;
        if (m_run > 5) s_rlv = 1;
        m_hist = {m_hist[5:0], b};
        if (m_fill < 7) m_fill++;
        if (m_fill == 7 && m_hist == 7'b0011111) s_comma = 1;
        m_cnt++;
        if (m_cnt == WIN) begin
            exp_rlv = s_rlv;
            exp_ncd = !s_comma;
            exp_dv  = !(s_rlv || !s_comma);
            s_rlv = 0; s_comma = 0; m_cnt = 0;
        end
    endtask

    task automatic step(input logic v, input logic b);
        @(negedge clk);
        check(data_valid, exp_dv, cur_tag);
        check(win_rlv_err, exp_rlv, "R2 run flag");
        check(win_ncd_err, exp_ncd, "R3 comma flag");
        bit_valid = v; bit_in = b;
        if (v) model_bit(b);
    endtask

    task automatic send_word(input logic [9:0] w);
        for (int i = 9; i >= 0; i--) step(1'b1, w[i]);
    endtask

    task automatic send_run(input logic b, input int len);
        for (int i = 0; i < len; i++) step(1'b1, b);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; bit_valid = 0;
        repeat (2) @(negedge clk);
        check(data_valid, 1'b0, "R1 reset dv");
        check(win_rlv_err, 1'b0, "R1 reset rlv");
        check(win_ncd_err, 1'b0, "R1 reset ncd");
        rst = 0;
        model_reset();
    endtask

    localparam logic [9:0] K_WORD   = 10'b0011111010;
    localparam logic [9:0] ALT_WORD = 10'b0101010101;

    initial begin
        model_reset();
        do_reset();
        cur_tag = "R1 first cycle";
        step(1'b0, 1'b0);

        cur_tag = "R7 clean windows";
        repeat (8) send_word(K_WORD);

        cur_tag = "R6 no comma";
        repeat (8) send_word(ALT_WORD);
        cur_tag = "R6 held low until clean";
        send_word(ALT_WORD);
        cur_tag = "R7 recovery";
        repeat (8) send_word(K_WORD);

        cur_tag = "R2 run sweep";
        for (int len = 1; len <= 8; len++) begin
            for (int b = 0; b < 2; b++) begin
                send_word(K_WORD);
                send_run(b[0], len);
                send_run(!b[0], 1);
                repeat (3) send_word(K_WORD);
            end
        end

        cur_tag = "R8 gapped bits";
        for (int k = 0; k < 8; k++) begin
            for (int i = 9; i >= 0; i--) begin
                step(1'b1, K_WORD[i]);
                step(1'b0, ~K_WORD[i]);
                if (i == 4) step(1'b0, 1'b1);
            end
        end
        cur_tag = "R8 gapped run";
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 1'b1);
            step(1'b0, 1'b0);
        end
        step(1'b1, 1'b0);
        repeat (8) send_word(K_WORD);

        cur_tag = "R9 comma straddle";
        while (m_cnt != 0) step(1'b1, m_cnt[0]);
        while (m_cnt != WIN - 4) step(1'b1, m_cnt[0]);
        send_word(K_WORD);
        while (m_cnt != WIN - 3) step(1'b1, m_cnt[0] ^ 1'b1);
        cur_tag = "R9 run straddle";
        send_run(1'b1, 3);
        send_run(1'b1, 3);
        send_run(1'b0, 1);
        repeat (8) send_word(K_WORD);

        cur_tag = "R4 history cleared";
        send_run(1'b0, 2);
        send_run(1'b1, 4);
        do_reset();
        step(1'b1, 1'b1);
        repeat (7) send_word(ALT_WORD);
        cur_tag = "R4 fresh commas";
        repeat (8) send_word(K_WORD);

        cur_tag = "R5 idle hold";
        repeat (4) step(1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule